// File: doc/BRIEF.md
# Regulator Start-Up Sequencer

This block orders the power-up of a switching regulator controller. Two comparator flags come in from the analog side. One says the bias supply is above its power-on threshold. The other says the shutdown pin has risen above its disable level. Both flags are asynchronous, so each passes through a synchronizer before the state machine uses it. The state machine moves through five phases in a fixed order: idle, a settling delay for the internal bias, overcurrent sampling, a short error-amplifier initialization, and the soft-start ramp. After the ramp it holds a ready state.

While the bias settles and the overcurrent level is captured, the low-side driver is held off. The sampling phase has no fixed length. It ends on a strobe from the sample-and-hold stage. The machine records that a valid sample exists and keeps that record for as long as the supply stays up. If either qualifying flag drops, the machine returns to idle and shuts every enable. Losing the supply also discards the stored sample. Every delay is a parameter counted in clock cycles.

Top module: `pwrseq_ctrl`

## Requirements
- R1: During and right after reset, `lgate_off` is 1 and `sample_en`, `ea_en`, `ss_en`, `ready` and `sample_valid` are all 0.
- R2: The sequence starts only when both `vcc_ok` and `sd_release` are high. Timing counts from whichever of the two rises last. `sample_en` rises exactly SYNC_STAGES+1+SETTLE_CYCLES cycles after that input rises.
- R3: `lgate_off` is 1 in every phase before soft-start. While `sd_release` is held low with the supply up, the machine stays idle with `sample_en` at 0.
- R4: `sample_en` stays high until `sample_done` is seen high in the sampling phase. A `sample_done` seen in any other phase has no effect. If `sample_done` is already high when sampling begins, `sample_en` is high for exactly one cycle.
- R5: In the cycle after `sample_done` ends sampling, `sample_en` is 0 and `sample_valid` is 1. Exactly INIT_CYCLES cycles after that, `ea_en` and `ss_en` go to 1 and `lgate_off` goes to 0.
- R6: `ss_en` stays high for exactly SS_CYCLES cycles. Then `ready` goes to 1 and `ss_en` goes to 0, while `ea_en` stays at 1.
- R7: If `vcc_ok` falls in any phase, SYNC_STAGES+1 cycles later all enables and `ready` are 0, `lgate_off` is 1 and `sample_valid` is 0.
- R8: If `sd_release` falls after start-up while the supply stays up, SYNC_STAGES+1 cycles later the machine is idle, as in R7, but `sample_valid` keeps its value.
- R9: At most one of `sample_en`, `ss_en` and `ready` is high at a time. `ea_en` is high exactly when `ss_en` or `ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vcc_ok | input | 1 | Supply above power-on threshold (asynchronous) |
| sd_release | input | 1 | Shutdown pin above disable level (asynchronous) |
| sample_done | input | 1 | Overcurrent sample complete strobe (synchronous) |
| lgate_off | output | 1 | Holds the low-side gate driver disabled |
| sample_en | output | 1 | Enables overcurrent sample-and-hold |
| ea_en | output | 1 | Enables the error amplifier |
| ss_en | output | 1 | Soft-start ramp running |
| ready | output | 1 | Start-up finished, output in regulation |
| sample_valid | output | 1 | A stored overcurrent sample is valid |

## Verification
A change on either flag input reaches the outputs SYNC_STAGES+1 cycles later: the synchronizer flops first, then the state register. `sample_done` acts after one cycle. Each phase boundary therefore falls on a cycle count that follows directly from the parameters. The bench drives inputs on the falling edge and counts falling edges from that point. At each boundary it samples twice: one cycle before the expected change, where the old value must still hold, and in the expected cycle, where the new value must appear. This pins every delay to the exact cycle rather than to a window.

// File: rtl/pwrseq_pkg.sv
// Shared definitions for the regulator start-up sequencer.
// Holds the phase encoding and the per-phase output decode,
// so that the state machine and the top use one definition.
package pwrseq_pkg;

    typedef enum logic [2:0] {
        PS_IDLE   = 3'd0,
        PS_SETTLE = 3'd1,
        PS_SAMPLE = 3'd2,
        PS_INIT   = 3'd3,
        PS_RAMP   = 3'd4,
        PS_READY  = 3'd5
    } pwrseq_state_e;

    typedef struct packed {
        logic lgate_off;
        logic sample_en;
        logic ea_en;
        logic ss_en;
        logic ready;
    } pwrseq_out_t;

    // Moore decode: the driver switches only once the ramp has begun.
    function automatic pwrseq_out_t pwrseq_decode(input pwrseq_state_e st);
        pwrseq_out_t o;
        o.lgate_off = !(st == PS_RAMP || st == PS_READY);
        o.sample_en = (st == PS_SAMPLE);
        o.ea_en     = (st == PS_RAMP || st == PS_READY);
        o.ss_en     = (st == PS_RAMP);
        o.ready     = (st == PS_READY);
        return o;
    endfunction

endpackage

// File: rtl/pwrseq_sync.sv
// Multi-flop synchronizer for asynchronous comparator flags.
// Assumes the flags are level signals that stay stable far longer
// than STAGES clock cycles. Resets to all zeros, so the system reads
// as "not qualified" during reset. STAGES = 0 gives a plain wire.
module pwrseq_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign q = d;
        end else begin : g_chain
            logic [WIDTH-1:0] stage_q [STAGES];

            // Shift the flags through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
                end else begin
                    stage_q[0] <= d;
                    for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
                end
            end

            assign q = stage_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/pwrseq_timer.sv
// Loadable down-counter used for the fixed-length phases.
// A load writes the terminal count minus one. The counter then
// decrements to zero and holds there. 'expired' is high while the
// count is zero. Load takes priority over counting.
module pwrseq_timer #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    // Reload on request, otherwise count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pwrseq_fsm.sv
// Phase sequencer for regulator start-up.
// Assumes the qualifier flags are already synchronized and that
// sample_done is synchronous to clk. Losing either qualifier forces
// idle ahead of any phase progress. Only a supply loss clears the
// sample-valid record.
module pwrseq_fsm
    import pwrseq_pkg::*;
#(
    parameter int unsigned CW            = 8,
    parameter int unsigned SETTLE_CYCLES = 20,
    parameter int unsigned INIT_CYCLES   = 4,
    parameter int unsigned SS_CYCLES     = 40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          vcc_q,
    input  logic          sd_q,
    input  logic          sample_done,
    input  logic          tmr_expired,
    output logic          tmr_load,
    output logic [CW-1:0] tmr_val,
    output pwrseq_state_e state,
    output logic          sample_valid
);

    localparam logic [CW-1:0] SETTLE_LD = CW'(SETTLE_CYCLES - 1);
    localparam logic [CW-1:0] INIT_LD   = CW'(INIT_CYCLES - 1);
    localparam logic [CW-1:0] SS_LD     = CW'(SS_CYCLES - 1);

    pwrseq_state_e state_q, state_d;
    logic          valid_q;
    logic          set_valid;
    logic          run;

    assign run = vcc_q & sd_q;

    // Next-phase selection and timer reload requests.
    always_comb begin
        state_d   = state_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        set_valid = 1'b0;
        if (!run) begin
            state_d = PS_IDLE;
        end else begin
            unique case (state_q)
                PS_IDLE: begin
                    state_d  = PS_SETTLE;
                    tmr_load = 1'b1;
                    tmr_val  = SETTLE_LD;
                end
                PS_SETTLE: begin
                    if (tmr_expired) state_d = PS_SAMPLE;
                end
                PS_SAMPLE: begin
                    if (sample_done) begin
                        state_d   = PS_INIT;
                        tmr_load  = 1'b1;
                        tmr_val   = INIT_LD;
                        set_valid = 1'b1;
                    end
                end
                PS_INIT: begin
                    if (tmr_expired) begin
                        state_d  = PS_RAMP;
                        tmr_load = 1'b1;
                        tmr_val  = SS_LD;
                    end
                end
                PS_RAMP: begin
                    if (tmr_expired) state_d = PS_READY;
                end
                PS_READY: state_d = PS_READY;
                default:  state_d = PS_IDLE;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PS_IDLE;
        else        state_q <= state_d;
    end

    // Sample-valid record: supply loss clears it, a completed sample sets it.
    always_ff @(posedge clk) begin
        if (!rst_n)         valid_q <= 1'b0;
        else if (!vcc_q)    valid_q <= 1'b0;
        else if (set_valid) valid_q <= 1'b1;
    end

    assign state        = state_q;
    assign sample_valid = valid_q;

endmodule

// File: rtl/pwrseq_ctrl.sv
// Top of the regulator start-up sequencer.
// Synchronizes the two comparator flags, runs the phase machine
// with a shared down-counter, and decodes the phase into the
// driver, sample, amplifier, ramp and ready controls. Every delay
// parameter must be at least 1.
module pwrseq_ctrl
    import pwrseq_pkg::*;
#(
    parameter int unsigned SYNC_STAGES   = 2,
    parameter int unsigned SETTLE_CYCLES = 20,
    parameter int unsigned INIT_CYCLES   = 4,
    parameter int unsigned SS_CYCLES     = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_ok,
    input  logic sd_release,
    input  logic sample_done,
    output logic lgate_off,
    output logic sample_en,
    output logic ea_en,
    output logic ss_en,
    output logic ready,
    output logic sample_valid
);

    localparam int unsigned MAX_A  = (SETTLE_CYCLES > INIT_CYCLES) ? SETTLE_CYCLES : INIT_CYCLES;
    localparam int unsigned MAX_CY = (MAX_A > SS_CYCLES) ? MAX_A : SS_CYCLES;
    localparam int unsigned CW     = $clog2(MAX_CY) + 1;

    logic [1:0]    flags_q;
    logic          vcc_q;
    logic          sd_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_expired;
    pwrseq_state_e state;
    pwrseq_out_t   dec;

    pwrseq_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({vcc_ok, sd_release}),
        .q     (flags_q)
    );

    assign vcc_q = flags_q[1];
    assign sd_q  = flags_q[0];

    pwrseq_timer #(
        .CW (CW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    pwrseq_fsm #(
        .CW            (CW),
        .SETTLE_CYCLES (SETTLE_CYCLES),
        .INIT_CYCLES   (INIT_CYCLES),
        .SS_CYCLES     (SS_CYCLES)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .vcc_q        (vcc_q),
        .sd_q         (sd_q),
        .sample_done  (sample_done),
        .tmr_expired  (tmr_expired),
        .tmr_load     (tmr_load),
        .tmr_val      (tmr_val),
        .state        (state),
        .sample_valid (sample_valid)
    );

    // Phase-to-control decode.
    always_comb dec = pwrseq_decode(state);

    assign lgate_off = dec.lgate_off;
    assign sample_en = dec.sample_en;
    assign ea_en     = dec.ea_en;
    assign ss_en     = dec.ss_en;
    assign ready     = dec.ready;

endmodule

// File: rtl/pwrseq_ctrl_chk.sv
// Assertion checker for the start-up sequencer, bound to the top.
// Observes the top's ports and its synchronized qualifier flags.
module pwrseq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic vcc_q,
    input logic sd_q,
    input logic sample_done,
    input logic lgate_off,
    input logic sample_en,
    input logic ea_en,
    input logic ss_en,
    input logic ready,
    input logic sample_valid
);

    assert_driver_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> lgate_off);

    assert_sample_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !sample_done && vcc_q && sd_q) |=> sample_en);

    assert_sample_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && sample_done && vcc_q && sd_q) |=> (sample_valid && !sample_en));

    assert_ramp_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_en) |-> ($past(!sample_en) && $past(!ea_en)));

    assert_ready_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(ss_en));

    assert_supply_loss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !vcc_q |=> (!sample_valid && !sample_en && !ss_en && !ready && !ea_en && lgate_off));

    assert_shutdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (vcc_q && !sd_q) |=> (!sample_en && !ss_en && !ready && !ea_en && lgate_off));

    assert_valid_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && vcc_q) |=> sample_valid);

    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sample_en, ss_en, ready}));

    assert_amp_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_en || ready) |-> (ea_en && !lgate_off));

endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .vcc_q        (vcc_q),
    .sd_q         (sd_q),
    .sample_done  (sample_done),
    .lgate_off    (lgate_off),
    .sample_en    (sample_en),
    .ea_en        (ea_en),
    .ss_en        (ss_en),
    .ready        (ready),
    .sample_valid (sample_valid)
);

// File: tb/pwrseq_ctrl_tb.sv
// Directed bench for the start-up sequencer. Inputs change on the
// falling edge and outputs are sampled on later falling edges.
module pwrseq_ctrl_tb;

    localparam int SYNC = 2;
    localparam int SETT = 6;
    localparam int INI  = 3;
    localparam int SSC  = 8;
    localparam int LAT  = SYNC + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vcc_ok = 1'b0;
    logic sd_release = 1'b0;
    logic sample_done = 1'b0;
    logic lgate_off, sample_en, ea_en, ss_en, ready, sample_valid;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pwrseq_ctrl #(
        .SYNC_STAGES   (SYNC),
        .SETTLE_CYCLES (SETT),
        .INIT_CYCLES   (INI),
        .SS_CYCLES     (SSC)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .vcc_ok       (vcc_ok),
        .sd_release   (sd_release),
        .sample_done  (sample_done),
        .lgate_off    (lgate_off),
        .sample_en    (sample_en),
        .ea_en        (ea_en),
        .ss_en        (ss_en),
        .ready        (ready),
        .sample_valid (sample_valid)
    );

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic chk_idle(input string req, input logic valid_exp);
        chk(req, "lgate_off", lgate_off, 1'b1);
        chk(req, "sample_en", sample_en, 1'b0);
        chk(req, "ea_en", ea_en, 1'b0);
        chk(req, "ss_en", ss_en, 1'b0);
        chk(req, "ready", ready, 1'b0);
        chk(req, "sample_valid", sample_valid, valid_exp);
    endtask

    task automatic power_off();
        vcc_ok = 1'b0; sd_release = 1'b0; sample_done = 1'b0;
        step(LAT + 2);
    endtask

    // Drive to the sampling phase from idle with both flags raised together.
    task automatic go_sample();
        vcc_ok = 1'b1; sd_release = 1'b1;
        step(LAT + SETT);
    endtask

    // Finish sampling and run through the ramp to ready.
    task automatic go_ready();
        sample_done = 1'b1; step(1); sample_done = 1'b0;
        step(INI + SSC);
    endtask

    task automatic t_reset();
        chk_idle("R1", 1'b0);
    endtask

    task automatic t_start_order();
        sd_release = 1'b1;
        step(5);
        chk("R2", "sample_en before supply", sample_en, 1'b0);
        vcc_ok = 1'b1;
        step(LAT + SETT - 1);
        chk("R2", "sample_en one cycle early", sample_en, 1'b0);
        chk("R3", "lgate_off in settle", lgate_off, 1'b1);
        step(1);
        chk("R2", "sample_en on time", sample_en, 1'b1);
        chk("R3", "lgate_off in sample", lgate_off, 1'b1);
        power_off();
    endtask

    task automatic t_sd_hold();
        vcc_ok = 1'b1; sd_release = 1'b0;
        step(40);
        chk("R3", "sample_en with shutdown held", sample_en, 1'b0);
        chk("R3", "lgate_off with shutdown held", lgate_off, 1'b1);
        sd_release = 1'b1;
        step(LAT + SETT - 1);
        chk("R3", "sample_en early after release", sample_en, 1'b0);
        step(1);
        chk("R3", "sample_en after release", sample_en, 1'b1);
    endtask

    // Continues from the sampling phase.
    task automatic t_full_run();
        step(25);
        chk("R4", "sample_en held without strobe", sample_en, 1'b1);
        chk("R4", "ss_en while waiting", ss_en, 1'b0);
        sample_done = 1'b1; step(1); sample_done = 1'b0;
        chk("R5", "sample_en after strobe", sample_en, 1'b0);
        chk("R5", "sample_valid after strobe", sample_valid, 1'b1);
        step(INI - 1);
        chk("R5", "ss_en early", ss_en, 1'b0);
        chk("R5", "ea_en early", ea_en, 1'b0);
        step(1);
        chk("R5", "ss_en on time", ss_en, 1'b1);
        chk("R5", "ea_en on time", ea_en, 1'b1);
        chk("R5", "lgate_off on time", lgate_off, 1'b0);
        step(SSC - 1);
        chk("R6", "ss_en last ramp cycle", ss_en, 1'b1);
        chk("R6", "ready early", ready, 1'b0);
        step(1);
        chk("R6", "ready on time", ready, 1'b1);
        chk("R6", "ss_en after ramp", ss_en, 1'b0);
        chk("R6", "ea_en after ramp", ea_en, 1'b1);
        chk("R9", "sample_en in ready", sample_en, 1'b0);
    endtask

    // Continues from ready.
    task automatic t_sd_drop();
        sd_release = 1'b0;
        step(LAT - 1);
        chk("R8", "ready before latency", ready, 1'b1);
        step(1);
        chk_idle("R8", 1'b1);
        sd_release = 1'b1;
        step(LAT + SETT);
        chk("R8", "restart reaches sampling", sample_en, 1'b1);
        go_ready();
        chk("R8", "ready after restart", ready, 1'b1);
    endtask

    // Continues from ready.
    task automatic t_vcc_drop();
        vcc_ok = 1'b0;
        step(LAT - 1);
        chk("R7", "ready before latency", ready, 1'b1);
        chk("R7", "valid before latency", sample_valid, 1'b1);
        step(1);
        chk_idle("R7", 1'b0);
        sd_release = 1'b0;
        step(2);
    endtask

    task automatic t_abort_in_sample();
        go_sample();
        chk("R7", "in sampling", sample_en, 1'b1);
        vcc_ok = 1'b0;
        step(LAT - 1);
        chk("R7", "sample_en before latency", sample_en, 1'b1);
        step(1);
        chk_idle("R7", 1'b0);
        power_off();
    endtask

    task automatic t_done_ignored();
        sample_done = 1'b1; step(3); sample_done = 1'b0;
        step(1);
        chk("R4", "valid after strobe in idle", sample_valid, 1'b0);
        sample_done = 1'b1;
        vcc_ok = 1'b1; sd_release = 1'b1;
        step(LAT + SETT - 1);
        chk("R4", "settle not cut short", sample_en, 1'b0);
        chk("R4", "no valid during settle", sample_valid, 1'b0);
        step(1);
        chk("R4", "zero-length sample visible", sample_en, 1'b1);
        step(1);
        chk("R4", "zero-length sample ends", sample_en, 1'b0);
        chk("R5", "valid after zero-length sample", sample_valid, 1'b1);
        sample_done = 1'b0;
        power_off();
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_start_order();
        t_sd_hold();
        t_full_run();
        t_sd_drop();
        t_vcc_drop();
        t_abort_in_sample();
        t_done_ignored();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        step(5000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule